// File: doc/BRIEF.md
# UART Baud and Oversampling Tick Generator

This block turns one fixed functional clock into the two timing strobes that a UART transmitter and receiver need. A one-cycle sample strobe fires at the oversampled rate. A one-cycle bit strobe fires once per group of oversamples. Software supplies a divisor N in the range 1 to 16,384 and picks a group size of 16 or 13 samples per bit. The resulting bit rate is f_clk / (group size × N). With the 48 MHz functional clock the block is intended for, the 13-sample mode reaches baud rates that the 16-sample mode cannot reach from the same clock.

Each sample strobe comes with a position index. The receiver uses it to find the middle of a bit cell. Changes to the divisor or the group size made while the block runs never cut a period short. A new divisor applies from the next sample period, and a new group size applies from the next bit. While the enable input is low, everything is held idle and the configuration inputs pass straight through.

Top module: `uart_baud_gen`

## Requirements
- R1: The 14-bit divisor code `div_i` gives N equal to the code itself for codes 1 to 16,383, and N = 16,384 for code 0.
- R2: While `en_i` is high, `sample_o` is high for exactly one clock every N clocks. The first pulse is visible in the cycle after the N-th rising edge at which `en_i` is high. With N = 1 it is high on every cycle.
- R3: With `osr13_i` = 0 (16-sample mode), `bit_o` is high only in a cycle where `sample_o` is high, and it is high on every 16th sample pulse.
- R4: With `osr13_i` = 1 (13-sample mode), `bit_o` is high on every 13th sample pulse.
- R5: While `en_i` is low, `sample_o` and `bit_o` stay low and `sample_idx_o` reads 0. These outputs are low/0 from the first cycle after an edge at which `en_i` is low. After re-enabling, counting restarts from zero.
- R6: In every cycle where `sample_o` is high, `sample_idx_o` gives that sample's position within the bit, counting 0, 1, 2 and so on. `bit_o` coincides with position 15 in 16-sample mode and with position 12 in 13-sample mode.
- R7: A divisor change made while running first takes effect for the sample period that starts after the current one ends. The period in progress keeps the old length.
- R8: A group-size change made while running first takes effect for the bit that starts after the current bit ends.
- R9: After reset, `sample_o` = 0, `bit_o` = 0 and `sample_idx_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the generator idle |
| div_i | input | 14 | Divisor code (0 means 16,384) |
| osr13_i | input | 1 | 0: 16 samples per bit, 1: 13 samples per bit |
| sample_o | output | 1 | One-cycle oversampling strobe |
| bit_o | output | 1 | One-cycle bit strobe, aligned with a sample strobe |
| sample_idx_o | output | 4 | Position of the current sample within the bit |

## Verification
All three outputs are registered. A strobe caused by a terminal count therefore shows up in the cycle after the edge at which the count matched. The first pulse after enabling is visible after the N-th edge, and disabling clears the outputs after one edge. The bench changes inputs and reads outputs on the falling clock edge, so it counts whole cycles between stimulus and result. A gap of N falling edges between sample pulses, 16 or 13 pulses between bit pulses, and a one-edge delay for disabling are all exact expected values. For the mid-run changes, the bench adds the cycles already spent in the current period to the cycles it measures afterwards. This checks that the old period length still applies to the period in progress.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned DIV_W = 14;
  localparam int unsigned IDX_W = 4;

  typedef enum logic {
    OSR_16 = 1'b0,
    OSR_13 = 1'b1
  } osr_e;

  function automatic logic [IDX_W-1:0] last_pos(osr_e m);
    return (m == OSR_13) ? IDX_W'(12) : IDX_W'(15);
  endfunction
endpackage

// File: rtl/baud_cfg.sv
module baud_cfg
  import baud_pkg::*;
#(
  parameter int unsigned W = DIV_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] div_i,
  input  logic         osr13_i,
  input  logic         smp_evt_i,
  input  logic         bit_evt_i,
  output logic [W-1:0] term_o,
  output osr_e         mode_o
);
  logic [W-1:0] code_q;
  osr_e         mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mode_q <= OSR_16;
    end else if (!en_i) begin
      code_q <= div_i;
      mode_q <= osr_e'(osr13_i);
    end else begin
      if (smp_evt_i) code_q <= div_i;
      if (bit_evt_i) mode_q <= osr_e'(osr13_i);
    end
  end

  // code-1 wraps 0 to all ones, i.e. terminal count 16383 for N = 16384
  assign term_o = code_q - W'(1);
  assign mode_o = mode_q;

  assert_div_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$past(smp_evt_i)) |-> $stable(code_q));
  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$past(bit_evt_i)) |-> $stable(mode_q));
endmodule

// File: rtl/baud_div.sv
module baud_div #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] term_i,
  output logic         evt_o,
  output logic         sample_o
);
  logic [W-1:0] cnt_q;
  logic         smp_q;

  assign evt_o = en_i && (cnt_q == term_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      smp_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      smp_q <= 1'b0;
    end else begin
      smp_q <= evt_o;
      cnt_q <= evt_o ? '0 : cnt_q + W'(1);
    end
  end

  assign sample_o = smp_q;

  assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (cnt_q <= term_i));
  assert_off_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sample_o);
endmodule

// File: rtl/baud_pos.sv
module baud_pos
  import baud_pkg::*;
#(
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          smp_evt_i,
  input  osr_e          mode_i,
  output logic          bit_evt_o,
  output logic          bit_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] pos_q, idx_q;
  logic          bit_q;

  assign bit_evt_o = smp_evt_i && (pos_q == last_pos(mode_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      idx_q <= '0;
      bit_q <= 1'b0;
    end else if (!en_i) begin
      pos_q <= '0;
      idx_q <= '0;
      bit_q <= 1'b0;
    end else begin
      bit_q <= bit_evt_o;
      if (smp_evt_i) begin
        idx_q <= pos_q;
        pos_q <= bit_evt_o ? '0 : pos_q + IW'(1);
      end
    end
  end

  assign bit_o = bit_q;
  assign idx_o = idx_q;

  assert_pos_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i == OSR_13) |-> (pos_q <= IW'(12)));
  assert_bit_on_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> (idx_o == IW'(15) || idx_o == IW'(12)));
  assert_off_idx_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (idx_o == '0 && !bit_o));
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned DW = DIV_W,
  parameter int unsigned IW = IDX_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] div_i,
  input  logic          osr13_i,
  output logic          sample_o,
  output logic          bit_o,
  output logic [IW-1:0] sample_idx_o
);
  logic [DW-1:0] term;
  osr_e          mode;
  logic          smp_evt, bit_evt;

  baud_cfg #(.W(DW)) u_cfg (
    .clk_i, .rst_ni, .en_i, .div_i, .osr13_i,
    .smp_evt_i(smp_evt), .bit_evt_i(bit_evt),
    .term_o(term), .mode_o(mode)
  );

  baud_div #(.W(DW)) u_div (
    .clk_i, .rst_ni, .en_i,
    .term_i(term), .evt_o(smp_evt), .sample_o(sample_o)
  );

  baud_pos #(.IW(IW)) u_pos (
    .clk_i, .rst_ni, .en_i,
    .smp_evt_i(smp_evt), .mode_i(mode),
    .bit_evt_o(bit_evt), .bit_o(bit_o), .idx_o(sample_idx_o)
  );

  assert_bit_with_sample_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_o |-> sample_o);
  assert_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && term != '0) |=> !sample_o);
endmodule

// File: tb/tb_uart_baud_gen.sv
module tb_uart_baud_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [13:0] div_i = 14'd4;
  logic        osr13_i = 1'b0;
  logic        sample_o, bit_o;
  logic [3:0]  sample_idx_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  uart_baud_gen dut (.*);

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: act cyc=%0d exp <150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // counts falling edges until sample_o is seen high
  task automatic wait_sample(output int gap);
    gap = 0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk_i);
      gap++;
      if (sample_o) return;
    end
    gap = -1;
  endtask

  task automatic start(input int code, input logic m13);
    @(negedge clk_i);
    en_i = 1'b0;
    div_i = 14'(code);
    osr13_i = m13;
    @(negedge clk_i);
    en_i = 1'b1;
  endtask

  task automatic t_reset();
    chk("R9 sample", int'(sample_o), 0);
    chk("R9 bit", int'(bit_o), 0);
    chk("R9 idx", int'(sample_idx_o), 0);
  endtask

  task automatic t_period();
    int g;
    start(5, 1'b0);
    wait_sample(g); chk("R2 first", g, 5);
    wait_sample(g); chk("R2 period", g, 5);
    wait_sample(g); chk("R2 period2", g, 5);
    start(1, 1'b0);
    wait_sample(g); chk("R2 N1 first", g, 1);
    wait_sample(g); chk("R2 N1 next", g, 1);
    start(16383, 1'b0);
    wait_sample(g); chk("R1 code16383", g, 16383);
    start(0, 1'b0);
    wait_sample(g); chk("R1 code0", g, 16384);
  endtask

  task automatic t_bits(input logic m13, input int len, string req);
    int g, bad, n;
    start(2, m13);
    bad = 0;
    n = 0;
    for (int b = 0; b < 2; b++) begin
      for (int s = 0; s < len; s++) begin
        wait_sample(g);
        n++;
        if (g != 2 || int'(sample_idx_o) != s) bad++;
        if (int'(bit_o) != ((s == len - 1) ? 1 : 0)) bad++;
      end
    end
    chk({req, " bit every group"}, bad, 0);
    chk({req, " samples"}, n, 2 * len);
  endtask

  task automatic t_disable();
    int g, bad;
    start(3, 1'b0);
    for (int s = 0; s < 6; s++) wait_sample(g);
    en_i = 1'b0;
    bad = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk_i);
      if (sample_o || bit_o || sample_idx_o != 4'd0) bad++;
    end
    chk("R5 quiet while off", bad, 0);
    en_i = 1'b1;
    wait_sample(g);
    chk("R5 restart gap", g, 3);
    chk("R5 restart idx", int'(sample_idx_o), 0);
  endtask

  task automatic t_div_change();
    int g;
    start(5, 1'b0);
    wait_sample(g);
    div_i = 14'd3;
    wait_sample(g); chk("R7 old period kept", g, 5);
    wait_sample(g); chk("R7 new period", g, 3);
    div_i = 14'd7;
    @(negedge clk_i);
    @(negedge clk_i);
    wait_sample(g); chk("R7 mid change old", g + 2, 3);
    wait_sample(g); chk("R7 mid change new", g, 7);
  endtask

  task automatic t_mode_change();
    int g, n;
    start(2, 1'b0);
    do wait_sample(g); while (sample_idx_o != 4'd4);
    osr13_i = 1'b1;
    do wait_sample(g); while (!bit_o);
    chk("R8 current bit keeps 16", int'(sample_idx_o), 15);
    n = 0;
    do begin wait_sample(g); n++; end while (!bit_o && n < 40);
    chk("R8 next bit 13 samples", n, 13);
    chk("R8 last idx", int'(sample_idx_o), 12);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_period();
    t_bits(1'b0, 16, "R3 R6");
    t_bits(1'b1, 13, "R4 R6");
    t_disable();
    t_div_change();
    t_mode_change();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule